// File: doc/BRIEF.md
# Multithreaded Issue Thread Selector

This block chooses, every cycle, which of four hardware thread contexts may place instructions into an in-order superscalar issue stage, and how many instructions each chosen thread may send. A static mode input picks one of three policies: a simultaneous policy that lets two threads split a two-wide issue budget, a fine-grained policy that runs one thread four wide and moves on whenever that thread stalls, and a coarse-grained policy that runs one thread eight wide and leaves it only when it takes an L1 miss.

For each thread the selector tracks three things: a fixed post-load/post-branch stall window, a pending-miss flag, and whether the common start (barrier release) has been seen. From these it works out which threads are eligible, and then picks among them in round-robin order. The outputs are plain control signals that the issue stage uses in the same cycle. There is no data stream and no back-pressure: the issue stage reports each load or branch it sent through the per-thread load/branch inputs in the cycle it sends it.

Top module: `mt_issue_sel`

## Requirements
- R1: After reset no slot is valid and every width is zero. No thread is eligible until the cycle after `start_i` is high; from that cycle on, all four threads are eligible together.
- R2: A high `ldbr_i[t]` in cycle k makes thread t ineligible in cycles k+1, k+2 and k+3. The thread is eligible again in k+4.
- R3: `miss_i` with `miss_tid_i`=t in cycle k makes thread t ineligible from cycle k+1 until the cycle after `miss_ret_i[t]` is high. If the miss and the return for the same thread arrive in the same cycle, the miss wins.
- R4: A thread is eligible only when its ready input is high, it has started, it has no stall window and no pending miss. The round-robin search begins at the thread after the last one granted, and reset sets that start point to thread 0.
- R5: With `mode_i`=0 (simultaneous), the two first eligible threads in round-robin order are granted one instruction each. If only one thread is eligible, it is granted two.
- R6: With `mode_i`=1 (fine-grained), at most one thread is granted, with width 4. The current thread is kept while it is eligible. Otherwise the selector takes the next eligible thread in round-robin order.
- R7: With `mode_i`=2 (coarse-grained), at most one thread is granted, with width 8. The current thread is kept through stalls and not-ready cycles, and nothing issues in those cycles. The selector switches only when the current thread has a pending miss.
- R8: When no thread is selected, both slot valids are low and `width_o` is all zero.
- R9: Slot 0 always carries the first thread found in round-robin order. Slot 1 is valid only in simultaneous mode, only alongside slot 0, and only with a different thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Policy: 0 simultaneous, 1 fine-grained, 2 coarse-grained. Held static |
| start_i | input | 1 | Barrier release that enables all threads |
| thr_ready_i | input | 4 | Per-thread ready flags |
| ldbr_i | input | 4 | Per-thread flag: a load or branch was issued this cycle |
| miss_i | input | 1 | L1 miss pulse |
| miss_tid_i | input | 2 | Thread that took the miss |
| miss_ret_i | input | 4 | Per-thread miss return that clears the pending miss |
| slot0_vld_o | output | 1 | Slot 0 holds a selected thread |
| slot0_tid_o | output | 2 | Thread in slot 0 |
| slot1_vld_o | output | 1 | Slot 1 holds a second thread |
| slot1_tid_o | output | 2 | Thread in slot 1 |
| width_o | output | 16 | Issue width per thread, 4 bits per thread, thread t at bits 4t+3:4t |

## Verification
The checker assumes that `ldbr_i[t]` is raised only in a cycle where thread t is granted, and that `mode_i` changes only while reset is held. It also assumes code 3 is never applied to `mode_i`, and that every input is low during reset. The stimulus table follows these rules. Load/branch flags appear only on rows where the expected result grants that thread, and each change of mode sits on a reset row. Miss pulses and returns are placed to reach the interesting cases, including a miss and a return arriving together and a coarse-grained miss with no other thread ready.

// File: rtl/mt_sel_pkg.sv
package mt_sel_pkg;

  typedef enum logic [1:0] {
    MODE_SMT    = 2'd0,
    MODE_FINE   = 2'd1,
    MODE_COARSE = 2'd2
  } issue_mode_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/mt_thr_ctx.sv
module mt_thr_ctx #(
  parameter int STALL_CYC = 3,
  localparam int CW = $clog2(STALL_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic ready_i,
  input  logic ldbr_i,
  input  logic miss_set_i,
  input  logic miss_clr_i,
  output logic elig_o,
  output logic missed_o
);

  logic [CW-1:0] stall_q;
  logic          miss_q;

  // stall window: loaded on a load/branch, counts down to zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q <= '0;
    end else if (ldbr_i) begin
      stall_q <= CW'(STALL_CYC);
    end else if (stall_q != '0) begin
      stall_q <= stall_q - 1'b1;
    end
  end

  // pending miss: a new miss takes priority over a return
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_q <= 1'b0;
    end else if (miss_set_i) begin
      miss_q <= 1'b1;
    end else if (miss_clr_i) begin
      miss_q <= 1'b0;
    end
  end

  assign elig_o   = run_i && ready_i && (stall_q == '0) && !miss_q;
  assign missed_o = miss_q;

endmodule

// File: rtl/mt_rr_pick.sv
module mt_rr_pick #(
  parameter int N_THR = 4,
  localparam int TW = (N_THR > 1) ? $clog2(N_THR) : 1
) (
  input  logic [N_THR-1:0] req_i,
  input  logic [TW-1:0]    base_i,
  output logic             found_o,
  output logic [TW-1:0]    idx_o
);

  always_comb begin
    int j;
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = 0; k < N_THR; k++) begin
      j = (int'(base_i) + k) % N_THR;
      if (!found_o && req_i[j]) begin
        found_o = 1'b1;
        idx_o   = TW'(j);
      end
    end
  end

endmodule

// File: rtl/mt_issue_sel.sv
module mt_issue_sel
  import mt_sel_pkg::*;
#(
  parameter int N_THR     = 4,
  parameter int STALL_CYC = 3,
  parameter int SMT_W     = 2,
  parameter int FG_W      = 4,
  parameter int CG_W      = 8,
  localparam int TW = (N_THR > 1) ? $clog2(N_THR) : 1,
  localparam int WW = $clog2(max3(SMT_W, FG_W, CG_W) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              start_i,
  input  logic [N_THR-1:0]  thr_ready_i,
  input  logic [N_THR-1:0]  ldbr_i,
  input  logic              miss_i,
  input  logic [TW-1:0]     miss_tid_i,
  input  logic [N_THR-1:0]  miss_ret_i,
  output logic              slot0_vld_o,
  output logic [TW-1:0]     slot0_tid_o,
  output logic              slot1_vld_o,
  output logic [TW-1:0]     slot1_tid_o,
  output logic [N_THR*WW-1:0] width_o
);

  localparam int SMT_HALF = SMT_W / 2;

  issue_mode_e mode;
  assign mode = issue_mode_e'(mode_i);

  logic             run_q;
  logic [TW-1:0]    cur_q;
  logic [TW-1:0]    ptr_q;
  logic [N_THR-1:0] elig;
  logic [N_THR-1:0] missed;

  // ---------------------------------------------------------------- contexts
  for (genvar t = 0; t < N_THR; t++) begin : g_ctx
    mt_thr_ctx #(.STALL_CYC(STALL_CYC)) i_ctx (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (run_q),
      .ready_i    (thr_ready_i[t]),
      .ldbr_i     (ldbr_i[t]),
      .miss_set_i (miss_i && (miss_tid_i == TW'(t))),
      .miss_clr_i (miss_ret_i[t]),
      .elig_o     (elig[t]),
      .missed_o   (missed[t])
    );
  end

  // ---------------------------------------------------------------- pickers
  logic          a_found, b_found;
  logic [TW-1:0] a_idx, b_idx, a_next;
  logic [N_THR-1:0] b_req;

  mt_rr_pick #(.N_THR(N_THR)) i_pick_a (
    .req_i   (elig),
    .base_i  (ptr_q),
    .found_o (a_found),
    .idx_o   (a_idx)
  );

  always_comb begin
    a_next = (int'(a_idx) == N_THR - 1) ? '0 : a_idx + 1'b1;
    b_req  = elig;
    b_req[a_idx] = 1'b0;
  end

  mt_rr_pick #(.N_THR(N_THR)) i_pick_b (
    .req_i   (b_req),
    .base_i  (a_next),
    .found_o (b_found),
    .idx_o   (b_idx)
  );

  // ---------------------------------------------------------------- policy
  always_comb begin
    slot0_vld_o = 1'b0;
    slot0_tid_o = '0;
    slot1_vld_o = 1'b0;
    slot1_tid_o = '0;
    unique case (mode)
      MODE_SMT: begin
        slot0_vld_o = a_found;
        slot0_tid_o = a_idx;
        slot1_vld_o = a_found && b_found;
        slot1_tid_o = b_idx;
      end
      MODE_COARSE: begin
        if (missed[cur_q]) begin
          slot0_vld_o = a_found;
          slot0_tid_o = a_idx;
        end else begin
          slot0_vld_o = elig[cur_q];
          slot0_tid_o = cur_q;
        end
      end
      default: begin
        if (elig[cur_q]) begin
          slot0_vld_o = 1'b1;
          slot0_tid_o = cur_q;
        end else begin
          slot0_vld_o = a_found;
          slot0_tid_o = a_idx;
        end
      end
    endcase
  end

  // ---------------------------------------------------------------- widths
  for (genvar t = 0; t < N_THR; t++) begin : g_w
    always_comb begin
      width_o[t*WW +: WW] = '0;
      if (slot0_vld_o && slot0_tid_o == TW'(t)) begin
        if (mode == MODE_SMT) begin
          width_o[t*WW +: WW] = slot1_vld_o ? WW'(SMT_HALF) : WW'(SMT_W);
        end else if (mode == MODE_COARSE) begin
          width_o[t*WW +: WW] = WW'(CG_W);
        end else begin
          width_o[t*WW +: WW] = WW'(FG_W);
        end
      end else if (slot1_vld_o && slot1_tid_o == TW'(t)) begin
        width_o[t*WW +: WW] = WW'(SMT_HALF);
      end
    end
  end

  // ---------------------------------------------------------------- state
  logic [TW-1:0] last_tid, last_next;
  always_comb begin
    last_tid  = slot1_vld_o ? slot1_tid_o : slot0_tid_o;
    last_next = (int'(last_tid) == N_THR - 1) ? '0 : last_tid + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cur_q <= '0;
      ptr_q <= '0;
    end else begin
      if (start_i) begin
        run_q <= 1'b1;
      end
      if (slot0_vld_o) begin
        cur_q <= last_tid;
        ptr_q <= last_next;
      end
    end
  end

endmodule

// File: rtl/mt_issue_sel_chk.sv
module mt_issue_sel_chk
  import mt_sel_pkg::*;
#(
  parameter int N_THR     = 4,
  parameter int STALL_CYC = 3,
  parameter int SMT_W     = 2,
  parameter int FG_W      = 4,
  parameter int CG_W      = 8,
  localparam int TW = (N_THR > 1) ? $clog2(N_THR) : 1,
  localparam int WW = $clog2(max3(SMT_W, FG_W, CG_W) + 1),
  localparam int CW = $clog2(STALL_CYC + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_i,
  input logic              start_i,
  input logic [N_THR-1:0]  thr_ready_i,
  input logic [N_THR-1:0]  ldbr_i,
  input logic              miss_i,
  input logic [TW-1:0]     miss_tid_i,
  input logic [N_THR-1:0]  miss_ret_i,
  input logic              slot0_vld_o,
  input logic [TW-1:0]     slot0_tid_o,
  input logic              slot1_vld_o,
  input logic [TW-1:0]     slot1_tid_o,
  input logic [N_THR*WW-1:0] width_o
);

  logic       seen_start;
  logic [31:0] wsum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_start <= 1'b0;
    else if (start_i) seen_start <= 1'b1;
  end

  always_comb begin
    wsum = '0;
    for (int t = 0; t < N_THR; t++) wsum = wsum + 32'(width_o[t*WW +: WW]);
  end

  // R1: nothing issues before the barrier release
  a_r1_no_early_issue: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_start |-> !slot0_vld_o);

  // R5: combined simultaneous width bounded
  a_r5_smt_budget: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_SMT) |-> (wsum <= 32'(SMT_W)));

  // R8: idle cycle grants nothing
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !slot0_vld_o |-> (!slot1_vld_o && width_o == '0));

  // R9: second slot only alongside first, simultaneous mode, distinct thread
  a_r9_second_slot: assert property (@(posedge clk) disable iff (!rst_n)
    slot1_vld_o |-> (slot0_vld_o && mode_i == MODE_SMT && slot1_tid_o != slot0_tid_o));

  // R6: fine-grained grants a single thread at full width
  a_r6_fine_single: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_FINE && slot0_vld_o) |->
      (!slot1_vld_o && width_o[slot0_tid_o*WW +: WW] == WW'(FG_W)));

  logic [N_THR-1:0] pend_miss;

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    logic [CW-1:0] gap;
    logic          sel;
    assign sel = (slot0_vld_o && slot0_tid_o == TW'(t)) ||
                 (slot1_vld_o && slot1_tid_o == TW'(t));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gap <= '0;
      else if (ldbr_i[t]) gap <= CW'(STALL_CYC);
      else if (gap != '0) gap <= gap - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_miss[t] <= 1'b0;
      else if (miss_i && miss_tid_i == TW'(t)) pend_miss[t] <= 1'b1;
      else if (miss_ret_i[t]) pend_miss[t] <= 1'b0;
    end

    // R2: stall window after a load or branch
    a_r2_stall_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (gap != '0) |-> !sel);

    // R3: a thread with a pending miss is never granted
    a_r3_miss_block: assert property (@(posedge clk) disable iff (!rst_n)
      pend_miss[t] |-> !sel);

    // R4: only ready threads are granted
    a_r4_ready_only: assert property (@(posedge clk) disable iff (!rst_n)
      sel |-> thr_ready_i[t]);
  end

  // R7: coarse mode leaves a thread only after it missed
  a_r7_coarse_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_COARSE && slot0_vld_o && $past(slot0_vld_o) &&
     slot0_tid_o != $past(slot0_tid_o)) |-> pend_miss[$past(slot0_tid_o)]);

endmodule

bind mt_issue_sel mt_issue_sel_chk #(
  .N_THR(N_THR), .STALL_CYC(STALL_CYC), .SMT_W(SMT_W), .FG_W(FG_W), .CG_W(CG_W)
) i_chk (.*);

// File: tb/test_mt_issue_sel.sv
module test_mt_issue_sel;

  typedef struct packed {
    logic       rst;
    logic       st;
    logic [1:0] md;
    logic [3:0] rdy;
    logic [3:0] ld;
    logic       ms;
    logic [1:0] mt;
    logic [3:0] mr;
    logic       e0v;
    logic [1:0] e0t;
    logic       e1v;
    logic [1:0] e1t;
    logic [3:0] rq;
  } vec_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        start_i = 1'b0;
  logic [3:0]  thr_ready_i = 4'h0;
  logic [3:0]  ldbr_i = 4'h0;
  logic        miss_i = 1'b0;
  logic [1:0]  miss_tid_i = 2'd0;
  logic [3:0]  miss_ret_i = 4'h0;
  logic        slot0_vld_o, slot1_vld_o;
  logic [1:0]  slot0_tid_o, slot1_tid_o;
  logic [15:0] width_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  mt_issue_sel i_mt_issue_sel (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .start_i(start_i),
    .thr_ready_i(thr_ready_i), .ldbr_i(ldbr_i), .miss_i(miss_i),
    .miss_tid_i(miss_tid_i), .miss_ret_i(miss_ret_i),
    .slot0_vld_o(slot0_vld_o), .slot0_tid_o(slot0_tid_o),
    .slot1_vld_o(slot1_vld_o), .slot1_tid_o(slot1_tid_o),
    .width_o(width_o)
  );

  // rst st md rdy ld ms mt mr | e0v e0t e1v e1t | requirement
  localparam vec_t TBL [46] = '{
    // simultaneous mode
    '{1'b1,1'b0,2'd0,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b0,2'd0,1'b0,2'd0, 4'd1}, // R1 reset
    '{1'b0,1'b0,2'd0,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b0,2'd0,1'b0,2'd0, 4'd1}, // R1 before start
    '{1'b0,1'b1,2'd0,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b0,2'd0,1'b0,2'd0, 4'd1}, // R1 start cycle
    '{1'b0,1'b0,2'd0,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd0,1'b1,2'd1, 4'd5}, // R5
    '{1'b0,1'b0,2'd0,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd2,1'b1,2'd3, 4'd4}, // R4
    '{1'b0,1'b0,2'd0,4'hF,4'h1,1'b0,2'd0,4'h0, 1'b1,2'd0,1'b1,2'd1, 4'd2}, // R2 load on 0
    '{1'b0,1'b0,2'd0,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd2,1'b1,2'd3, 4'd2}, // R2
    '{1'b0,1'b0,2'd0,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd1,1'b1,2'd2, 4'd2}, // R2 0 skipped
    '{1'b0,1'b0,2'd0,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd3,1'b1,2'd1, 4'd9}, // R9 wrap order
    '{1'b0,1'b0,2'd0,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd2,1'b1,2'd3, 4'd2}, // R2 0 back
    '{1'b0,1'b0,2'd0,4'h4,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd2,1'b0,2'd0, 4'd5}, // R5 single gets 2
    '{1'b0,1'b0,2'd0,4'h0,4'h0,1'b0,2'd0,4'h0, 1'b0,2'd0,1'b0,2'd0, 4'd8}, // R8 idle
    '{1'b0,1'b0,2'd0,4'hF,4'h0,1'b1,2'd3,4'h0, 1'b1,2'd3,1'b1,2'd0, 4'd3}, // R3 miss on 3
    '{1'b0,1'b0,2'd0,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd1,1'b1,2'd2, 4'd3}, // R3
    '{1'b0,1'b0,2'd0,4'hF,4'h0,1'b0,2'd0,4'h8, 1'b1,2'd0,1'b1,2'd1, 4'd3}, // R3 return 3
    '{1'b0,1'b0,2'd0,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd2,1'b1,2'd3, 4'd3}, // R3 3 back
    '{1'b0,1'b0,2'd0,4'hF,4'h0,1'b1,2'd1,4'h2, 1'b1,2'd0,1'b1,2'd1, 4'd3}, // R3 miss+return
    '{1'b0,1'b0,2'd0,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd2,1'b1,2'd3, 4'd3}, // R3
    '{1'b0,1'b0,2'd0,4'hF,4'h0,1'b0,2'd0,4'h2, 1'b1,2'd0,1'b1,2'd2, 4'd3}, // R3 miss held
    '{1'b0,1'b0,2'd0,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd3,1'b1,2'd0, 4'd4}, // R4
    // fine-grained mode
    '{1'b1,1'b0,2'd1,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b0,2'd0,1'b0,2'd0, 4'd1}, // R1
    '{1'b0,1'b1,2'd1,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b0,2'd0,1'b0,2'd0, 4'd1}, // R1
    '{1'b0,1'b0,2'd1,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd0,1'b0,2'd0, 4'd6}, // R6
    '{1'b0,1'b0,2'd1,4'hF,4'h1,1'b0,2'd0,4'h0, 1'b1,2'd0,1'b0,2'd0, 4'd6}, // R6 hold
    '{1'b0,1'b0,2'd1,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd1,1'b0,2'd0, 4'd6}, // R6 switch
    '{1'b0,1'b0,2'd1,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd1,1'b0,2'd0, 4'd6}, // R6 hold
    '{1'b0,1'b0,2'd1,4'hD,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd2,1'b0,2'd0, 4'd6}, // R6 not ready
    '{1'b0,1'b0,2'd1,4'hF,4'h4,1'b0,2'd0,4'h0, 1'b1,2'd2,1'b0,2'd0, 4'd6}, // R6
    '{1'b0,1'b0,2'd1,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd3,1'b0,2'd0, 4'd6}, // R6
    '{1'b0,1'b0,2'd1,4'hF,4'h0,1'b1,2'd3,4'h0, 1'b1,2'd3,1'b0,2'd0, 4'd3}, // R3
    '{1'b0,1'b0,2'd1,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd0,1'b0,2'd0, 4'd3}, // R3 moved off
    // coarse-grained mode
    '{1'b1,1'b0,2'd2,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b0,2'd0,1'b0,2'd0, 4'd1}, // R1
    '{1'b0,1'b1,2'd2,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b0,2'd0,1'b0,2'd0, 4'd7}, // R7
    '{1'b0,1'b0,2'd2,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd0,1'b0,2'd0, 4'd7}, // R7
    '{1'b0,1'b0,2'd2,4'hF,4'h1,1'b0,2'd0,4'h0, 1'b1,2'd0,1'b0,2'd0, 4'd7}, // R7 load
    '{1'b0,1'b0,2'd2,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b0,2'd0,1'b0,2'd0, 4'd7}, // R7 stalled hold
    '{1'b0,1'b0,2'd2,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b0,2'd0,1'b0,2'd0, 4'd7}, // R7
    '{1'b0,1'b0,2'd2,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b0,2'd0,1'b0,2'd0, 4'd7}, // R7
    '{1'b0,1'b0,2'd2,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd0,1'b0,2'd0, 4'd2}, // R2 resumes
    '{1'b0,1'b0,2'd2,4'hE,4'h0,1'b0,2'd0,4'h0, 1'b0,2'd0,1'b0,2'd0, 4'd7}, // R7 not ready
    '{1'b0,1'b0,2'd2,4'hF,4'h0,1'b1,2'd0,4'h0, 1'b1,2'd0,1'b0,2'd0, 4'd7}, // R7 miss
    '{1'b0,1'b0,2'd2,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd1,1'b0,2'd0, 4'd7}, // R7 switched
    '{1'b0,1'b0,2'd2,4'hF,4'h0,1'b0,2'd0,4'h1, 1'b1,2'd1,1'b0,2'd0, 4'd7}, // R7
    '{1'b0,1'b0,2'd2,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd1,1'b0,2'd0, 4'd7}, // R7 stays
    '{1'b0,1'b0,2'd2,4'hF,4'h0,1'b1,2'd1,4'h0, 1'b1,2'd1,1'b0,2'd0, 4'd7}, // R7
    '{1'b0,1'b0,2'd2,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd2,1'b0,2'd0, 4'd4}  // R4 next after 1
  };

  function automatic logic [15:0] exp_width(vec_t v);
    logic [15:0] w;
    w = '0;
    for (int t = 0; t < 4; t++) begin
      if (v.e0v && v.e0t == 2'(t)) begin
        if (v.md == 2'd0)      w[t*4 +: 4] = v.e1v ? 4'd1 : 4'd2;
        else if (v.md == 2'd1) w[t*4 +: 4] = 4'd4;
        else                   w[t*4 +: 4] = 4'd8;
      end else if (v.e1v && v.e1t == 2'(t)) begin
        w[t*4 +: 4] = 4'd1;
      end
    end
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v, input int row);
    @(negedge clk);
    rst_n       = !v.rst;
    start_i     = v.st;
    mode_i      = v.md;
    thr_ready_i = v.rdy;
    ldbr_i      = v.ld;
    miss_i      = v.ms;
    miss_tid_i  = v.mt;
    miss_ret_i  = v.mr;
    #5;
    check($sformatf("R%0d row %0d slot0", v.rq, row),
          {29'd0, slot0_vld_o, slot0_vld_o ? slot0_tid_o : 2'd0},
          {29'd0, v.e0v, v.e0v ? v.e0t : 2'd0});
    check($sformatf("R%0d row %0d slot1", v.rq, row),
          {29'd0, slot1_vld_o, slot1_vld_o ? slot1_tid_o : 2'd0},
          {29'd0, v.e1v, v.e1v ? v.e1t : 2'd0});
    check($sformatf("R%0d row %0d width", v.rq, row),
          {16'd0, width_o}, {16'd0, exp_width(v)});
  endtask

  initial begin
    for (int i = 0; i < 46; i++) apply(TBL[i], i);

    // directed: coarse miss with no other thread ready (R7, R8)
    apply('{1'b1,1'b0,2'd2,4'h1,4'h0,1'b0,2'd0,4'h0, 1'b0,2'd0,1'b0,2'd0, 4'd1}, 100); // R1
    apply('{1'b0,1'b1,2'd2,4'h1,4'h0,1'b0,2'd0,4'h0, 1'b0,2'd0,1'b0,2'd0, 4'd1}, 101); // R1
    apply('{1'b0,1'b0,2'd2,4'h1,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd0,1'b0,2'd0, 4'd7}, 102); // R7
    apply('{1'b0,1'b0,2'd2,4'h1,4'h0,1'b1,2'd0,4'h0, 1'b1,2'd0,1'b0,2'd0, 4'd7}, 103); // R7
    apply('{1'b0,1'b0,2'd2,4'h1,4'h0,1'b0,2'd0,4'h0, 1'b0,2'd0,1'b0,2'd0, 4'd8}, 104); // R8
    apply('{1'b0,1'b0,2'd2,4'h1,4'h0,1'b0,2'd0,4'h1, 1'b0,2'd0,1'b0,2'd0, 4'd3}, 105); // R3
    apply('{1'b0,1'b0,2'd2,4'h1,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd0,1'b0,2'd0, 4'd3}, 106); // R3

    // directed: reset mid-run returns pointer to thread 0 (R4)
    apply('{1'b0,1'b0,2'd2,4'h1,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd0,1'b0,2'd0, 4'd7}, 107); // R7
    apply('{1'b1,1'b0,2'd0,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b0,2'd0,1'b0,2'd0, 4'd1}, 108); // R1
    apply('{1'b0,1'b1,2'd0,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b0,2'd0,1'b0,2'd0, 4'd1}, 109); // R1
    apply('{1'b0,1'b0,2'd0,4'hA,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd1,1'b1,2'd3, 4'd4}, 110); // R4
    apply('{1'b0,1'b0,2'd0,4'hF,4'h0,1'b0,2'd0,4'h0, 1'b1,2'd0,1'b1,2'd1, 4'd4}, 111); // R4

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule